// File: doc/BRIEF.md
# External Static Memory Bus Sequencer

This block turns single requests from an internal valid/ready port into cycle-timed strobe sequences on an asynchronous external parallel memory bus. Each request carries an address, a read/write flag and write data. The address is decoded into one of six active-low chip selects. The block then drives chip select, address-valid, output enable, write enable, the address, the write data and a data-out enable. The width of every phase comes from timing fields that are held separately for each chip select. A read response returns the data captured from the bus, or flags a decode miss.

Between accesses the block inserts idle recovery cycles only where a device may still be driving the data bus. This happens when a read is followed by an access to another chip select, or by a write to the same chip select. A single register write port loads one chip select's timing word at a time. A timing word must not be rewritten while an access to that chip select is in progress.

Top module: `ext_mem_seq`

## Requirements
- R1: Addresses decode to chip selects as follows. Index 0 covers 0x1A800000..0x1AFFFFFF. Index 1 covers 0x1B000000..0x1B7FFFFF. Index 2 covers 0x1B800000..0x1BFFFFFF. Index 5 covers 0x1C000000..0x1C7FFFFF. Index 4 covers 0x1C800000..0x1CFFFFFF. Index 3 covers 0x1D000000..0x24FFFFFF. Chip select k is bit k of mem_cs_n_o, driven low. At most one bit is low at a time.
- R2: An address outside every window is answered in the cycle after acceptance. The response has rsp_err_o=1 and rsp_rdata_o=0, and no strobe is driven. The error flag is high only in the response cycle.
- R3: A read holds its chip select low for (rl+1)+(ao+1)+(rh+1)+(rw+1) cycles. Address-valid is low only in the first of these cycles. Output enable first goes low rl+ao+2 cycles after the address-valid cycle and then stays low for rh+rw+2 cycles.
- R4: Read data is captured in the last output-enable cycle and is returned on rsp_rdata_o when rsp_valid_o pulses. A write response returns zero.
- R5: A write holds its chip select low for (wl+1)+(ww+1)+(wh+1) cycles. Write enable goes low for ww+1 cycles after the latency phase. The hold phase that follows lasts wh+1 cycles. Data-out enable is high, with the request data on mem_wdata_o, for the whole time the chip select is low.
- R6: Recovery is inserted before an access when the previous decoded access was a read and the new access either targets another chip select or is a write. Recovery lasts max(rc,1) cycles, where rc is the recovery field of the previous read's chip select. During recovery all strobes are inactive.
- R7: No recovery is inserted after a write, nor between reads to the same chip select.
- R8: When address hold is set for the chip select, one extra cycle follows the last strobe cycle. In that cycle the address stays on mem_addr_o with all strobes inactive.
- R9: When cfg_we_i is high, cfg_wdata_i is loaded into the timing word of chip select cfg_sel_i. Select values 6 and 7 are ignored. The word layout is: rc [3:0], wh [7:4], wl [12:8], rl [17:13], ww [21:18], rw [25:22], rh [29:26], ao [32:30], address hold [33]. All words reset to zero.
- R10: req_ready_o is high only while the block is idle. It is high in every response cycle, so a new request can be accepted in the cycle of the previous response.
- R11: Output enable and write enable are never low together, and data-out enable is never high while output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Timing word write strobe |
| cfg_sel_i | input | 3 | Chip select index of the timing word |
| cfg_wdata_i | input | 34 | Timing word value |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 32 | Request address |
| req_wdata_i | input | DATA_W | Write data |
| rsp_valid_o | output | 1 | One-cycle response pulse |
| rsp_rdata_o | output | DATA_W | Read data |
| rsp_err_o | output | 1 | Decode miss flag |
| mem_cs_n_o | output | 6 | Chip selects, active low |
| mem_adv_n_o | output | 1 | Address valid, active low |
| mem_oe_n_o | output | 1 | Output enable, active low |
| mem_we_n_o | output | 1 | Write enable, active low |
| mem_addr_o | output | 32 | Bus address, zero when idle |
| mem_wdata_o | output | DATA_W | Bus write data |
| mem_dout_en_o | output | 1 | Data bus driver enable |
| mem_rdata_i | input | DATA_W | Bus read data |

## Verification
The response pulse of one access and the acceptance of the next fall in the same idle cycle. In that cycle the block must also decide whether to insert recovery, based on the access that has just finished. The driver issues requests back to back so that every acceptance lands in a response cycle. The sequences include read-to-write on the same chip select, read to another chip select, write-to-read, read-to-read and misses in between. The monitor counts the idle cycles before the first chip-select cycle and the total busy cycles of each access. It compares them with the recovery that the previous access should have caused.

// File: rtl/ems_pkg.sv
package ems_pkg;
  localparam int unsigned ADDR_W   = 32;
  localparam int unsigned NUM_CS   = 6;
  localparam int unsigned CS_IDX_W = $clog2(NUM_CS);
  localparam int unsigned CNT_W    = 5;

  typedef struct packed {
    logic       addr_hold;  // [33]
    logic [2:0] adv_oe;     // [32:30]
    logic [3:0] rd_hold;    // [29:26]
    logic [3:0] rd_wait;    // [25:22]
    logic [3:0] wr_wait;    // [21:18]
    logic [4:0] rd_lat;     // [17:13]
    logic [4:0] wr_lat;     // [12:8]
    logic [3:0] wr_hold;    // [7:4]
    logic [3:0] recov;      // [3:0]
  } cs_timing_t;

  localparam int unsigned CFG_W = $bits(cs_timing_t);

  typedef enum logic [2:0] {
    ST_IDLE, ST_REC, ST_LAT, ST_AOE, ST_RDH, ST_WAIT, ST_WHOLD, ST_AHOLD
  } phase_e;

  localparam logic [ADDR_W-1:0] WIN_LO [NUM_CS] = '{
    32'h1A80_0000, 32'h1B00_0000, 32'h1B80_0000,
    32'h1D00_0000, 32'h1C80_0000, 32'h1C00_0000};
  localparam logic [ADDR_W-1:0] WIN_HI [NUM_CS] = '{
    32'h1AFF_FFFF, 32'h1B7F_FFFF, 32'h1BFF_FFFF,
    32'h24FF_FFFF, 32'h1CFF_FFFF, 32'h1C7F_FFFF};
endpackage

// File: rtl/ems_decode.sv
module ems_decode
  import ems_pkg::*;
(
  input  logic [ADDR_W-1:0]   addr_i,
  output logic                hit_o,
  output logic [CS_IDX_W-1:0] idx_o
);
  logic [NUM_CS-1:0] match;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_win
    assign match[g] = (addr_i >= WIN_LO[g]) && (addr_i <= WIN_HI[g]);
  end

  always_comb begin
    idx_o = '0;
    for (int i = NUM_CS - 1; i >= 0; i--) begin
      if (match[i]) idx_o = CS_IDX_W'(i);
    end
  end

  assign hit_o = |match;
endmodule

// File: rtl/ems_timing_regs.sv
module ems_timing_regs
  import ems_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [CS_IDX_W-1:0] cfg_sel_i,
  input  logic [CFG_W-1:0]    cfg_wdata_i,
  output cs_timing_t          timing_o [NUM_CS]
);
  cs_timing_t regs_q [NUM_CS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_CS; i++) regs_q[i] <= '0;
    end else if (cfg_we_i) begin
      for (int i = 0; i < NUM_CS; i++) begin
        if (cfg_sel_i == CS_IDX_W'(i)) regs_q[i] <= cs_timing_t'(cfg_wdata_i);
      end
    end
  end

  assign timing_o = regs_q;
endmodule

// File: rtl/ems_fsm.sv
module ems_fsm
  import ems_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic                req_we_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic [DATA_W-1:0]   req_wdata_i,
  input  logic                dec_hit_i,
  input  logic [CS_IDX_W-1:0] dec_idx_i,
  input  cs_timing_t          timing_i [NUM_CS],
  output logic                rsp_valid_o,
  output logic [DATA_W-1:0]   rsp_rdata_o,
  output logic                rsp_err_o,
  output logic [NUM_CS-1:0]   mem_cs_n_o,
  output logic                mem_adv_n_o,
  output logic                mem_oe_n_o,
  output logic                mem_we_n_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [DATA_W-1:0]   mem_wdata_o,
  output logic                mem_dout_en_o,
  input  logic [DATA_W-1:0]   mem_rdata_i
);
  phase_e              state_q, state_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d, rec_load;
  logic                cur_we_q, prev_rd_q, rsp_valid_q, rsp_err_q;
  logic [CS_IDX_W-1:0] cur_idx_q, prev_idx_q;
  logic [ADDR_W-1:0]   cur_addr_q;
  logic [DATA_W-1:0]   cur_wdata_q, rdata_q;
  logic [3:0]          rec_f;
  logic                accept, need_rec, last_cyc, strobing;
  cs_timing_t          cur_t;

  function automatic logic [CNT_W-1:0] load_of(phase_e p, cs_timing_t t, logic we);
    case (p)
      ST_LAT:   return we ? t.wr_lat : t.rd_lat;
      ST_AOE:   return CNT_W'(t.adv_oe);
      ST_RDH:   return CNT_W'(t.rd_hold);
      ST_WAIT:  return we ? CNT_W'(t.wr_wait) : CNT_W'(t.rd_wait);
      ST_WHOLD: return CNT_W'(t.wr_hold);
      default:  return '0;
    endcase
  endfunction

  function automatic phase_e next_of(phase_e p, logic we, logic ah);
    case (p)
      ST_REC:   return ST_LAT;
      ST_LAT:   return we ? ST_WAIT : ST_AOE;
      ST_AOE:   return ST_RDH;
      ST_RDH:   return ST_WAIT;
      ST_WAIT:  return we ? ST_WHOLD : (ah ? ST_AHOLD : ST_IDLE);
      ST_WHOLD: return ah ? ST_AHOLD : ST_IDLE;
      default:  return ST_IDLE;
    endcase
  endfunction

  assign cur_t    = timing_i[cur_idx_q];
  assign accept   = req_valid_i && (state_q == ST_IDLE);
  // bus may still be driven by the last read's device
  assign need_rec = prev_rd_q && (req_we_i || (dec_idx_i != prev_idx_q));
  assign last_cyc = (cnt_q == '0);
  assign rec_f    = timing_i[prev_idx_q].recov;
  assign rec_load = (rec_f == '0) ? '0 : CNT_W'(rec_f - 4'd1);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (state_q == ST_IDLE) begin
      if (accept && dec_hit_i) begin
        if (need_rec) begin
          state_d = ST_REC;
          cnt_d   = rec_load;
        end else begin
          state_d = ST_LAT;
          cnt_d   = load_of(ST_LAT, timing_i[dec_idx_i], req_we_i);
        end
      end
    end else if (!last_cyc) begin
      cnt_d = cnt_q - 1'b1;
    end else begin
      state_d = next_of(state_q, cur_we_q, cur_t.addr_hold);
      cnt_d   = load_of(state_d, cur_t, cur_we_q);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      cur_we_q    <= 1'b0;
      cur_idx_q   <= '0;
      cur_addr_q  <= '0;
      cur_wdata_q <= '0;
      prev_rd_q   <= 1'b0;
      prev_idx_q  <= '0;
      rdata_q     <= '0;
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
    end else begin
      state_q     <= state_d;
      cnt_q       <= cnt_d;
      rsp_valid_q <= (accept && !dec_hit_i) ||
                     ((state_q != ST_IDLE) && last_cyc && (state_d == ST_IDLE));
      rsp_err_q   <= accept && !dec_hit_i;
      if (accept) begin
        cur_we_q    <= req_we_i;
        cur_addr_q  <= req_addr_i;
        cur_wdata_q <= req_wdata_i;
        rdata_q     <= '0;
        if (dec_hit_i) begin
          cur_idx_q  <= dec_idx_i;
          prev_rd_q  <= !req_we_i;
          prev_idx_q <= dec_idx_i;
        end
      end else if ((state_q == ST_WAIT) && last_cyc && !cur_we_q) begin
        rdata_q <= mem_rdata_i;
      end
    end
  end

  assign strobing      = state_q inside {ST_LAT, ST_AOE, ST_RDH, ST_WAIT, ST_WHOLD};
  assign req_ready_o   = (state_q == ST_IDLE);
  assign rsp_valid_o   = rsp_valid_q;
  assign rsp_err_o     = rsp_err_q;
  assign rsp_rdata_o   = rdata_q;
  assign mem_cs_n_o    = strobing ? ~(NUM_CS'(1) << cur_idx_q) : '1;
  assign mem_adv_n_o   = !((state_q == ST_LAT) && (cnt_q == load_of(ST_LAT, cur_t, cur_we_q)));
  assign mem_oe_n_o    = !(!cur_we_q && (state_q inside {ST_RDH, ST_WAIT}));
  assign mem_we_n_o    = !(cur_we_q && (state_q == ST_WAIT));
  assign mem_dout_en_o = cur_we_q && (state_q inside {ST_LAT, ST_WAIT, ST_WHOLD});
  assign mem_addr_o    = (strobing || (state_q == ST_AHOLD)) ? cur_addr_q : '0;
  assign mem_wdata_o   = mem_dout_en_o ? cur_wdata_q : '0;

  // R1
  cs_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~mem_cs_n_o));
  // R3
  oe_in_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_n_o |-> !(&mem_cs_n_o));
  // R11
  oe_we_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!mem_oe_n_o && !mem_we_n_o));
  // R11
  no_contention_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dout_en_o |-> mem_oe_n_o);
  // R6
  drive_after_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_oe_n_o) |=> !mem_dout_en_o);
  // R2
  miss_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> (rsp_valid_o && (rsp_rdata_o == '0) && (&mem_cs_n_o)));
  // R10
  busy_after_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && dec_hit_i) |=> !req_ready_o);
endmodule

// File: rtl/ext_mem_seq.sv
module ext_mem_seq
  import ems_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [CS_IDX_W-1:0] cfg_sel_i,
  input  logic [CFG_W-1:0]    cfg_wdata_i,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic                req_we_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic [DATA_W-1:0]   req_wdata_i,
  output logic                rsp_valid_o,
  output logic [DATA_W-1:0]   rsp_rdata_o,
  output logic                rsp_err_o,
  output logic [NUM_CS-1:0]   mem_cs_n_o,
  output logic                mem_adv_n_o,
  output logic                mem_oe_n_o,
  output logic                mem_we_n_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [DATA_W-1:0]   mem_wdata_o,
  output logic                mem_dout_en_o,
  input  logic [DATA_W-1:0]   mem_rdata_i
);
  logic                dec_hit;
  logic [CS_IDX_W-1:0] dec_idx;
  cs_timing_t          timing [NUM_CS];

  ems_decode u_decode (
    .addr_i (req_addr_i),
    .hit_o  (dec_hit),
    .idx_o  (dec_idx)
  );

  ems_timing_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_sel_i   (cfg_sel_i),
    .cfg_wdata_i (cfg_wdata_i),
    .timing_o    (timing)
  );

  ems_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_valid_i   (req_valid_i),
    .req_ready_o   (req_ready_o),
    .req_we_i      (req_we_i),
    .req_addr_i    (req_addr_i),
    .req_wdata_i   (req_wdata_i),
    .dec_hit_i     (dec_hit),
    .dec_idx_i     (dec_idx),
    .timing_i      (timing),
    .rsp_valid_o   (rsp_valid_o),
    .rsp_rdata_o   (rsp_rdata_o),
    .rsp_err_o     (rsp_err_o),
    .mem_cs_n_o    (mem_cs_n_o),
    .mem_adv_n_o   (mem_adv_n_o),
    .mem_oe_n_o    (mem_oe_n_o),
    .mem_we_n_o    (mem_we_n_o),
    .mem_addr_o    (mem_addr_o),
    .mem_wdata_o   (mem_wdata_o),
    .mem_dout_en_o (mem_dout_en_o),
    .mem_rdata_i   (mem_rdata_i)
  );
endmodule

// File: tb/ext_mem_seq_tb.sv
`timescale 1ns/1ps
module ext_mem_seq_tb;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_sel = '0;
  logic [33:0]   cfg_wdata = '0;
  logic          req_valid = 1'b0, req_we = 1'b0;
  logic [31:0]   req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rsp_valid, rsp_err;
  logic [DW-1:0] rsp_rdata, mem_wdata, mem_rdata;
  logic [5:0]    mem_cs_n;
  logic          mem_adv_n, mem_oe_n, mem_we_n, mem_dout_en;
  logic [31:0]   mem_addr;

  always #4 clk = ~clk;

  ext_mem_seq #(.DATA_W(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_wdata_i(cfg_wdata), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_we_i(req_we), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .rsp_err_o(rsp_err),
    .mem_cs_n_o(mem_cs_n), .mem_adv_n_o(mem_adv_n), .mem_oe_n_o(mem_oe_n),
    .mem_we_n_o(mem_we_n), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_dout_en_o(mem_dout_en), .mem_rdata_i(mem_rdata));

  // bus device model: drives data only while output enable is low
  assign mem_rdata = mem_oe_n ? '0 : (mem_addr[15:0] ^ 16'hA5C3);

  typedef struct {
    bit          we, err;
    int          idx, rec, cs, oe, a2o, wel, wh, ahold, busy;
    logic [31:0] a;
    logic [15:0] rdata, wd;
  } exp_t;
  exp_t sb_q[$];

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // configuration model
  int m_rc[6], m_wh[6], m_wl[6], m_rl[6], m_ww[6], m_rw[6], m_rh[6], m_ao[6], m_ah[6];
  bit b_prev_rd = 0;
  int b_prev_idx = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic void dec_m(input logic [31:0] a, output bit hit, output int idx);
    hit = 1; idx = 0;
    if (a < 32'h1A80_0000)      hit = 0;
    else if (a < 32'h1B00_0000) idx = 0;
    else if (a < 32'h1B80_0000) idx = 1;
    else if (a < 32'h1C00_0000) idx = 2;
    else if (a < 32'h1C80_0000) idx = 5;
    else if (a < 32'h1D00_0000) idx = 4;
    else if (a < 32'h2500_0000) idx = 3;
    else hit = 0;
  endfunction

  // monitor state
  bit mon_on = 0, cs_seen, we_seen;
  int m_busy, m_rec, m_cs, m_oe, m_we, m_wh_c, m_den, m_adv, m_ahold;
  int adv_at, oe_at, m_cs_bad, m_wd_bad, m_clash;
  exp_t cur;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (mon_on) begin
        if (!req_ready) begin
          if (&mem_cs_n) begin
            if (!cs_seen) m_rec++;
            else if (mem_addr == cur.a) m_ahold++;
          end else begin
            cs_seen = 1;
            m_cs++;
            if (mem_cs_n != ~(6'b1 << cur.idx)) m_cs_bad++;
            if (!mem_we_n) begin m_we++; we_seen = 1; end
            else if (we_seen) m_wh_c++;
          end
          if (!mem_oe_n) begin
            if (m_oe == 0) oe_at = m_busy;
            m_oe++;
          end
          if (!mem_adv_n) begin adv_at = m_busy; m_adv++; end
          if (mem_dout_en) begin
            m_den++;
            if (mem_wdata != cur.wd) m_wd_bad++;
          end
          if ((!mem_oe_n && !mem_we_n) || (mem_dout_en && !mem_oe_n)) m_clash++;
          m_busy++;
        end
        if (rsp_valid) begin
          exp_t e;
          e = sb_q.pop_front();
          mon_on = 0;
          chk(rsp_err == e.err, "R2 err flag", int'(rsp_err), int'(e.err));
          chk(rsp_rdata == e.rdata, e.we ? "R4 write rdata" : "R4 read data",
              int'(rsp_rdata), int'(e.rdata));
          chk(m_busy == e.busy, "R10 busy cycles", m_busy, e.busy);
          chk(m_rec == e.rec, (e.rec > 0) ? "R6 recovery" : "R7 no recovery", m_rec, e.rec);
          chk(m_cs_bad == 0, "R1 chip select line", m_cs_bad, 0);
          chk(m_clash == 0, "R11 strobe overlap", m_clash, 0);
          if (e.err) begin
            chk(m_cs + m_oe + m_we + m_adv == 0, "R2 no strobes", m_cs + m_oe + m_we + m_adv, 0);
          end else begin
            chk(m_ahold == e.ahold, "R8 address hold", m_ahold, e.ahold);
            chk(m_adv == 1, "R3 adv single cycle", m_adv, 1);
            chk(adv_at == e.rec, "R3 adv at cs start", adv_at, e.rec);
            if (e.we) begin
              chk(m_cs == e.cs, "R5 write cs length", m_cs, e.cs);
              chk(m_we == e.wel, "R5 we length", m_we, e.wel);
              chk(m_wh_c == e.wh, "R5 write hold", m_wh_c, e.wh);
              chk(m_den == e.cs, "R5 dout enable", m_den, e.cs);
              chk(m_wd_bad == 0, "R5 write data", m_wd_bad, 0);
            end else begin
              chk(m_cs == e.cs, "R3 read cs length", m_cs, e.cs);
              chk(m_oe == e.oe, "R3 oe length", m_oe, e.oe);
              chk(oe_at - adv_at == e.a2o, "R3 adv to oe", oe_at - adv_at, e.a2o);
              chk(m_den == 0, "R11 no drive on read", m_den, 0);
            end
          end
        end
      end else if (rsp_valid) begin
        chk(0, "R10 unexpected response", 1, 0);
      end
      if (req_valid && req_ready) begin
        cur = sb_q[0];
        mon_on = 1; cs_seen = 0; we_seen = 0;
        m_busy = 0; m_rec = 0; m_cs = 0; m_oe = 0; m_we = 0; m_wh_c = 0;
        m_den = 0; m_adv = 0; m_ahold = 0; adv_at = -1; oe_at = -1;
        m_cs_bad = 0; m_wd_bad = 0; m_clash = 0;
      end
    end
  end

  task automatic wait_idle();
    while (sb_q.size() != 0 || mon_on) @(negedge clk);
  endtask

  task automatic cfg(input int idx, input int rc, wh, wl, rl, ww, rw, rh, ao, ah);
    longint w;
    wait_idle();
    w = longint'(rc) | (longint'(wh) << 4) | (longint'(wl) << 8) | (longint'(rl) << 13) |
        (longint'(ww) << 18) | (longint'(rw) << 22) | (longint'(rh) << 26) |
        (longint'(ao) << 30) | (longint'(ah) << 33);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_sel = 3'(idx); cfg_wdata = w[33:0];
    @(posedge clk); #1;
    cfg_we = 1'b0;
    if (idx < 6) begin
      m_rc[idx] = rc; m_wh[idx] = wh; m_wl[idx] = wl; m_rl[idx] = rl; m_ww[idx] = ww;
      m_rw[idx] = rw; m_rh[idx] = rh; m_ao[idx] = ao; m_ah[idx] = ah;
    end
  endtask

  task automatic acc(input bit we, input logic [31:0] a, input logic [15:0] wd);
    exp_t e;
    bit hit;
    int idx;
    dec_m(a, hit, idx);
    e.we = we; e.a = a; e.wd = wd; e.idx = idx; e.err = !hit;
    e.rec = 0; e.cs = 0; e.oe = 0; e.a2o = 0; e.wel = 0; e.wh = 0; e.ahold = 0;
    e.busy = 0; e.rdata = '0;
    if (hit) begin
      if (b_prev_rd && (we || idx != b_prev_idx))
        e.rec = (m_rc[b_prev_idx] == 0) ? 1 : m_rc[b_prev_idx];
      if (we) begin
        e.cs = m_wl[idx] + m_ww[idx] + m_wh[idx] + 3;
        e.wel = m_ww[idx] + 1;
        e.wh = m_wh[idx] + 1;
      end else begin
        e.cs = m_rl[idx] + m_ao[idx] + m_rh[idx] + m_rw[idx] + 4;
        e.oe = m_rh[idx] + m_rw[idx] + 2;
        e.a2o = m_rl[idx] + m_ao[idx] + 2;
        e.rdata = a[15:0] ^ 16'hA5C3;
      end
      e.ahold = m_ah[idx];
      e.busy = e.rec + e.cs + e.ahold;
      b_prev_rd = !we;
      b_prev_idx = idx;
    end
    sb_q.push_back(e);
    @(posedge clk); #1;
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = wd;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // reset state
    chk(req_ready == 1'b1, "R10 ready in reset", int'(req_ready), 1);
    chk(mem_cs_n == 6'h3F, "R1 cs idle in reset", int'(mem_cs_n), 63);
    chk(mem_oe_n && mem_we_n && mem_adv_n, "R11 strobes idle in reset", 0, 1);
    chk(rsp_valid == 1'b0, "R2 no response in reset", int'(rsp_valid), 0);
    @(posedge clk); #1 rst_n = 1'b1;

    // minimum timings from reset words
    acc(0, 32'h1A80_0010, '0);
    acc(0, 32'h1A80_0012, '0);
    acc(1, 32'h1A80_0014, 16'h1234);

    cfg(0, 0, 2, 2, 3, 3, 2, 1, 2, 0);
    cfg(1, 15, 0, 1, 0, 0, 0, 15, 7, 1);
    cfg(3, 5, 3, 31, 31, 9, 9, 0, 0, 1);
    cfg(5, 2, 1, 0, 4, 2, 6, 2, 1, 0);

    acc(0, 32'h1A80_0100, '0);          // R7 write -> read, none
    acc(1, 32'h1A80_0102, 16'hBEEF);    // R6 read -> write same cs
    acc(1, 32'h1AFF_FFFE, 16'h0F0F);    // R7 write -> write
    acc(0, 32'h1A80_0104, '0);          // R7 write -> read
    acc(0, 32'h1A80_0106, '0);          // R7 read -> read same cs
    acc(0, 32'h1B00_0000, '0);          // R6 read cs0 -> cs1 (rc 0 gives 1)
    acc(0, 32'h1D00_0002, '0);          // R6 cs1 rc 15, R8 hold on cs3
    acc(1, 32'h24FF_FFFE, 16'hC3C3);    // R6 read -> write, cs3 rc 5
    acc(0, 32'h1A7F_FFFF, '0);          // R2 below first window
    acc(0, 32'h2500_0000, '0);          // R2 above last window
    acc(1, 32'h0000_0000, 16'h5555);    // R2 write miss
    acc(0, 32'h1BFF_FFFE, '0);          // R1 cs2 top, R7 after write
    acc(0, 32'h1C00_0000, '0);          // R1 cs5, R6 from cs2
    acc(0, 32'h1C80_0000, '0);          // R1 cs4, R6 from cs5 rc 2
    acc(1, 32'h1C7F_FFFE, 16'hA0A0);    // R5 cs5 write
    acc(0, 32'h1B7F_FFFE, '0);          // R1 cs1 top, R8

    // R9: select 6 and 7 must not disturb any timing word
    cfg(6, 15, 15, 31, 31, 15, 15, 15, 7, 1);
    cfg(7, 15, 15, 31, 31, 15, 15, 15, 7, 1);
    acc(0, 32'h1A80_0200, '0);          // R9 cs0 unchanged
    acc(1, 32'h1A80_0202, 16'h7E7E);    // R9 cs0 write unchanged
    wait_idle();
    repeat (3) @(negedge clk);
    chk(sb_q.size() == 0, "R10 all responses seen", sb_q.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL R10 watchdog expired act=0 exp=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule